// File: doc/BRIEF.md
# Serial Wiper Register Controller

This block holds the control state of a single-channel 8-bit digital potentiometer and takes its commands over a four-wire serial bus. The bus master selects the block with chip select low and sends a 16-bit frame, most significant bit first: an 8-bit command byte, then an 8-bit data byte. The block samples its serial input on each rising serial clock edge while selected. Nothing happens until chip select is released. At that moment the block checks the frame and then either loads a new wiper code or enters shutdown.

The serial clock, chip select and serial input are asynchronous to the system clock. Each passes through a two-stage synchronizer, and all edge detection runs in the system clock domain. For this to work, the serial clock's high and low phases must each last several system clock periods. The outputs are the wiper code and a shutdown flag. Together they drive the analog switch network, which is outside the block.

Top module: `spi_pot_slave`

## Requirements
- R1: A data bit is taken only on a rising serial clock edge seen while chip select is low. Serial clock edges while chip select is high change nothing.
- R2: Bits are shifted in most significant first. The first 8 bits form the command byte and the last 8 bits form the data byte.
- R3: In the command byte, bits 5:4 are the opcode and bit 0 is the potentiometer select. Bits 7, 6, 3, 2 and 1 are ignored.
- R4: Opcode 01 with select 1 loads the data byte into the wiper register.
- R5: Opcode 10 with select 1 sets the shutdown flag and leaves the wiper unchanged. Its data byte is ignored, but all 16 bits must still arrive.
- R6: A frame with select 0 changes neither output.
- R7: Opcodes 00 and 11 change neither output.
- R8: Outputs change only after chip select rises, never when the 16th bit arrives.
- R9: A frame with fewer or more than 16 counted bits is discarded with no change.
- R10: After reset the wiper is 0x80 and the shutdown flag is 0.
- R11: A valid wiper load clears the shutdown flag.
- R12: A serial clock rise detected in the same system cycle as the chip select rise is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| wiper_o | output | 8 | Current wiper code |
| shutdown_o | output | 1 | High while the potentiometer is disconnected |

## Verification
Two events can land in the same synchronized cycle: a serial clock rise, which would count a bit, and the chip select rise, which ends the frame and triggers execution. The bench provokes this by sending a full 16-bit frame and then driving a 17th clock rise together with the chip select rise. The frame must execute. If the coincident edge were counted, the bit count would reach 17 and the frame would be dropped, so the wiper value read afterwards shows which way the collision was resolved.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 8;
    localparam int OP_LSB = 4;
    localparam int SEL_BIT = 0;

    typedef enum logic [1:0] {
        OP_NOP0  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SHUT  = 2'b10,
        OP_NOP3  = 2'b11
    } pot_op_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RESET_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= async_i;
                end else begin
                    stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_pot_rx.sv
module spi_pot_rx #(
    parameter int FRAME_BITS = 16,
    localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_s,
    input  logic                  cs_n_s,
    input  logic                  sdi_s,
    output logic                  frame_end_o,
    output logic                  frame_full_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic                  sck_prev;
        logic                  cs_prev;
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic sck_rise, cs_fall, cs_rise;

    always_comb begin
        sck_rise = sck_s & ~st_q.sck_prev;
        cs_fall  = ~cs_n_s & st_q.cs_prev;
        cs_rise  = cs_n_s & ~st_q.cs_prev;
        st_d = st_q;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_n_s;
        if (cs_fall) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end else if (!cs_n_s && sck_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], sdi_s};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_prev <= 1'b0;
            st_q.cs_prev  <= 1'b1;
            st_q.shreg    <= '0;
            st_q.cnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_end_o  = cs_rise;
    assign frame_full_o = (st_q.cnt == CNT_FULL);
    assign frame_o      = st_q.shreg;

    // R1: nothing is counted while deselected
    a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(st_q.cnt) && $stable(st_q.shreg));

    // R9: counter saturates one past a full frame
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_OVER);

    // R12: a clock rise coinciding with the frame end never counts
    a_r12_no_count_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && sck_rise) |=> $stable(st_q.cnt));
endmodule

// File: rtl/spi_pot_exec.sv
module spi_pot_exec
    import spi_pot_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter logic [DATA_W-1:0] WIPER_RESET = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_end_i,
    input  logic                  frame_full_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic [DATA_W-1:0]     wiper_o,
    output logic                  shutdown_o
);
    typedef struct packed {
        logic [DATA_W-1:0] wiper;
        logic              shut;
    } pot_state_t;

    pot_state_t st_q, st_d;
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
    pot_op_e           op;
    logic              sel;
    logic              accept;

    always_comb begin
        cmd    = frame_i[FRAME_BITS-1 -: CMD_W];
        data   = frame_i[DATA_W-1:0];
        op     = pot_op_e'(cmd[OP_LSB +: 2]);
        sel    = cmd[SEL_BIT];
        accept = frame_end_i && frame_full_i && sel;
        st_d   = st_q;
        if (accept) begin
            case (op)
                OP_WRITE: begin
                    st_d.wiper = data;
                    st_d.shut  = 1'b0;
                end
                OP_SHUT:  st_d.shut = 1'b1;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wiper <= WIPER_RESET;
            st_q.shut  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wiper_o    = st_q.wiper;
    assign shutdown_o = st_q.shut;

    // R10: reset values on release
    a_r10_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.wiper == WIPER_RESET) && !st_q.shut);

    // R8: outputs move only right after a frame end
    a_r8_update_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end_i) |=> $stable(st_q));

    // R9: incomplete frames leave state untouched
    a_r9_discard_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !frame_full_i) |=> $stable(st_q));

    // R11: a wiper load clears shutdown and takes the data byte
    a_r11_load_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && frame_full_i && frame_i[FRAME_BITS-1-CMD_W+SEL_BIT+1]
         && frame_i[FRAME_BITS-CMD_W+OP_LSB+1 -: 2] == 2'b01)
        |=> !st_q.shut && st_q.wiper == $past(frame_i[DATA_W-1:0]));

    // R5: shutdown keeps the wiper
    a_r5_shut_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && frame_full_i && frame_i[FRAME_BITS-CMD_W+SEL_BIT]
         && frame_i[FRAME_BITS-CMD_W+OP_LSB+1 -: 2] == 2'b10)
        |=> st_q.shut && $stable(st_q.wiper));
endmodule

// File: rtl/spi_pot_slave.sv
module spi_pot_slave
    import spi_pot_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] WIPER_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    output logic [DATA_W-1:0] wiper_o,
    output logic              shutdown_o
);
    logic [2:0] pins_s;
    logic frame_end, frame_full;
    logic [FRAME_BITS-1:0] frame;

    spi_pot_sync #(
        .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sck_i, cs_n_i, sdi_i}),
        .sync_o(pins_s)
    );

    spi_pot_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[2]), .cs_n_s(pins_s[1]), .sdi_s(pins_s[0]),
        .frame_end_o(frame_end), .frame_full_o(frame_full), .frame_o(frame)
    );

    spi_pot_exec #(.FRAME_BITS(FRAME_BITS), .WIPER_RESET(WIPER_RESET)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .frame_end_i(frame_end), .frame_full_i(frame_full), .frame_i(frame),
        .wiper_o(wiper_o), .shutdown_o(shutdown_o)
    );
endmodule

// File: tb/spi_pot_slave_test.sv
module spi_pot_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic [7:0] wiper;
    logic shut;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_pot_slave uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi),
        .wiper_o(wiper), .shutdown_o(shut)
    );

    // {frame[15:0], bit count[7:0], expected wiper[7:0], expected shutdown}
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {16'h1155, 8'd16, 8'h55, 1'b0},  // R4 load
        {16'h21AA, 8'd16, 8'h55, 1'b1},  // R5 shutdown, data ignored
        {16'h11C3, 8'd16, 8'hC3, 1'b0},  // R11 load wakes
        {16'h1077, 8'd16, 8'hC3, 1'b0},  // R6 select 0
        {16'h0177, 8'd16, 8'hC3, 1'b0},  // R7 opcode 00
        {16'h3177, 8'd16, 8'hC3, 1'b0},  // R7 opcode 11
        {16'hD13C, 8'd16, 8'h3C, 1'b0},  // R3 ignored bits set
        {16'h1199, 8'd15, 8'h3C, 1'b0},  // R9 short
        {16'h1199, 8'd17, 8'h3C, 1'b0},  // R9 long
        {16'hE1FF, 8'd16, 8'h3C, 1'b1},  // R5 ignored bits, shutdown
        {16'h1100, 8'd16, 8'h00, 1'b0},  // R2 all zero data
        {16'h11FE, 8'd16, 8'hFE, 1'b0}   // R2 bit order
    };

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] exp_w, input logic exp_s);
        @(negedge clk);
        checks++;
        if (wiper !== exp_w || shut !== exp_s) begin
            errors++;
            $display("FAIL %s: wiper=%h shut=%b expected wiper=%h shut=%b",
                     req, wiper, shut, exp_w, exp_s);
        end
    endtask

    task automatic clock_bit(input logic b);
        sdi = b;
        wait_clk(3);
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
        wait_clk(3);
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input bit hold, input bit coincide);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) clock_bit(i < 16 ? w[15-i] : 1'b0);
        if (!hold) begin
            if (coincide) begin
                sdi = 1'b1;
                wait_clk(3);
                sck = 1'b1;
            end
            cs_n = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(8);
        end
    endtask

    initial begin
        wait_clk(5);
        check("R10 during reset", 8'h80, 1'b0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R10 after reset", 8'h80, 1'b0);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][32:17], int'(VEC[v][16:9]), 1'b0, 1'b0);
            check($sformatf("vector %0d", v), VEC[v][8:1], VEC[v][0]);
        end

        // R1: clock pulses while deselected do nothing, then a normal frame works
        for (int i = 0; i < 5; i++) clock_bit(1'b1);
        check("R1 deselected clocks", 8'hFE, 1'b0);
        send(16'h1142, 16, 1'b0, 1'b0);
        check("R1 frame after idle clocks", 8'h42, 1'b0);

        // R8: full frame held selected does not execute yet
        send(16'h11A5, 16, 1'b1, 1'b0);
        wait_clk(20);
        check("R8 before release", 8'h42, 1'b0);
        cs_n = 1'b1;
        wait_clk(10);
        check("R8 after release", 8'hA5, 1'b0);

        // R12: extra clock rise together with release is not counted
        send(16'h115A, 16, 1'b0, 1'b1);
        check("R12 coincident edge", 8'h5A, 1'b0);

        // R5 then R10: shutdown, then reset restores defaults
        send(16'h2100, 16, 1'b0, 1'b0);
        check("R5 shutdown keeps wiper", 8'h5A, 1'b1);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check("R10 re-reset", 8'h80, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                wait_clk(150000);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule